// File: doc/BRIEF.md
# Static RAM with Bulk Clear

This block is a clocked model of a 1024-word by 4-bit static memory. It has separate input and output data paths, a 10-bit word address and four active-low controls: chip select, write enable, output enable and clear. All controls are sampled on the rising clock edge. The output port carries an explicit drive flag in place of a three-state pad. While the flag is low the data lines are held at zero.

A clear is accepted only while the device is selected. It makes every word read back as zero, and the block is ready again two cycles after the clear is sampled. This means one shared clear line can wipe only the devices whose chip select is low. The array is built as 64 rows of sixteen 4-bit columns. The clear drops one valid bit per row instead of rewriting the storage. A row whose valid bit is low reads as zero. The first write into such a row fills its other columns with zeros.

The clear controller is a two-state machine. In state CS_IDLE the block serves reads and writes. The transition CS_IDLE to CS_WIPE is taken on a sampled clear. CS_WIPE stays in CS_WIPE while clear keeps being sampled. CS_WIPE returns to CS_IDLE on any other sample. While the machine is in CS_WIPE, the `clr_busy` output is high and reads and writes are refused.

Top module: `sram_clr_top`

## Requirements
- R1: After system reset (`rst_ni` low), `dout_en`, `dout`, `clr_busy` and `mode_err` are all 0, and every word reads back as 0.
- R2: With `cs_n`=0, `we_n`=0, `clr_n`=1 the block is in a write window. With `cs_n`=0, `we_n`=1, `oe_n`=0, `clr_n`=1 it is reading. A read sampled at edge k drives `dout_en`=1 and the stored word on `dout` after edge k. Consecutive read samples follow the address cycle by cycle.
- R3: A write window may last several cycles. The address and data sampled in the window's last cycle are stored when the window closes. Addresses presented earlier in the same window keep their old contents.
- R4: After any sample that is not a read, `dout_en` is 0 and `dout` is 0. This covers deselect, `oe_n` high, `we_n` low and `clr_n` low.
- R5: A sample with `cs_n`=0, `clr_n`=0, `we_n`=1 is a clear, and every word reads 0 afterwards. `clr_busy` is high in the cycle after each clear sample and low in the cycle after the first non-clear sample.
- R6: `clr_n`=0 while `cs_n`=1 has no effect: stored words are unchanged and `clr_busy` stays 0.
- R7: A read or write sampled while `clr_busy` is high is dropped. `dout_en` stays 0 and nothing is stored.
- R8: The row is `addr[9:4]` and the column is `addr[3:0]`. After a clear, writing one column of a row leaves every other column of that row reading 0.
- R9: A sample with `cs_n`=0, `clr_n`=0, `we_n`=0 is illegal. It raises `mode_err` for the following cycle, performs no clear, and discards any open write window without storing it.
- R10: A read of the same address sampled at the edge where a write window closes returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every control is sampled on its rising edge |
| rst_ni | input | 1 | Synchronous active-low system reset |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| clr_n | input | 1 | Bulk clear request, active low, gated by chip select |
| addr | input | 10 | Word address: row in the upper 6 bits, column in the lower 4 |
| din | input | 4 | Write data |
| dout | output | 4 | Registered read data, zero when not driving |
| dout_en | output | 1 | High when `dout` is driven with read data |
| clr_busy | output | 1 | High while the clear is settling |
| mode_err | output | 1 | High the cycle after an illegal control combination |

## Verification
The bench builds the block with its default parameters: a 10-bit address, 4-bit data and 4 column bits, which gives 64 rows of 16 columns. With these values it can reach both ends of the address range. It can also reach two columns of one row, which exercises the zero-fill of a cleared row, and addresses in rows that have never been written since reset. A flat reference memory in the bench predicts every output cycle, including the one-cycle busy window, the refused accesses inside it and the read that catches a write as its window closes.

// File: rtl/sram_clr_pkg.sv
package sram_clr_pkg;

    // Decoded operating mode of one sampled cycle
    typedef enum logic [2:0] {
        MD_DESEL,
        MD_OFF,
        MD_READ,
        MD_WRITE,
        MD_CLEAR,
        MD_ILLEGAL
    } mode_e;

    // Bulk clear controller states
    typedef enum logic {
        CS_IDLE,
        CS_WIPE
    } clr_state_e;

endpackage

// File: rtl/sram_mode_decode.sv
module sram_mode_decode
    import sram_clr_pkg::*;
(
    input  logic  cs_n_i,
    input  logic  we_n_i,
    input  logic  oe_n_i,
    input  logic  clr_n_i,
    output mode_e mode_o
);

    // Priority: select, then clear line, then write, then output enable
    always_comb begin
        if (cs_n_i) begin
            mode_o = MD_DESEL;
        end else if (!clr_n_i) begin
            mode_o = we_n_i ? MD_CLEAR : MD_ILLEGAL;
        end else if (!we_n_i) begin
            mode_o = MD_WRITE;
        end else if (!oe_n_i) begin
            mode_o = MD_READ;
        end else begin
            mode_o = MD_OFF;
        end
    end

endmodule

// File: rtl/sram_clear_fsm.sv
module sram_clear_fsm
    import sram_clr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_ni,
    input  mode_e mode_i,
    output logic  wipe_o,
    output logic  busy_o,
    output logic  rd_ok_o,
    output logic  wr_ok_o
);

    clr_state_e state_q, state_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_IDLE: if (mode_i == MD_CLEAR) state_d = CS_WIPE;
            CS_WIPE: if (mode_i != MD_CLEAR) state_d = CS_IDLE;
            default: state_d = CS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_ni) state_q <= CS_IDLE;
        else         state_q <= state_d;
    end

    // Outputs
    always_comb begin
        busy_o  = (state_q == CS_WIPE);
        wipe_o  = (mode_i == MD_CLEAR);
        rd_ok_o = (mode_i == MD_READ)  && !busy_o;
        wr_ok_o = (mode_i == MD_WRITE) && !busy_o;
    end

    // R5
    busy_after_clear_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        (mode_i == MD_CLEAR) |=> busy_o);

    // R5
    busy_release_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        (mode_i != MD_CLEAR) |=> !busy_o);

endmodule

// File: rtl/sram_row_array.sv
module sram_row_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 4,
    parameter int COL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_ni,
    input  logic              wipe_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam int ROW_W    = ADDR_W - COL_W;
    localparam int ROWS     = 2 ** ROW_W;
    localparam int COLS     = 2 ** COL_W;
    localparam int ROW_BITS = COLS * DATA_W;

    logic [ROW_BITS-1:0] mem_q [ROWS];
    logic [ROWS-1:0]     valid_q;

    logic [ROW_W-1:0]    wr_row, rd_row;
    logic [COL_W-1:0]    wr_col, rd_col;
    logic [ROW_BITS-1:0] wr_line, rd_line;

    assign wr_row = wr_addr_i[ADDR_W-1:COL_W];
    assign wr_col = wr_addr_i[COL_W-1:0];
    assign rd_row = rd_addr_i[ADDR_W-1:COL_W];
    assign rd_col = rd_addr_i[COL_W-1:0];

    // Build the new row: target column takes the data, the others keep
    // their value if the row is live, or become zero if it was cleared
    for (genvar c = 0; c < COLS; c++) begin : g_lane
        assign wr_line[c*DATA_W +: DATA_W] =
            (wr_col == COL_W'(c)) ? wr_data_i :
            (valid_q[wr_row] ? mem_q[wr_row][c*DATA_W +: DATA_W] : '0);
    end

    always_ff @(posedge clk) begin
        if (wr_en_i) mem_q[wr_row] <= wr_line;
    end

    always_ff @(posedge clk) begin
        if (!rst_ni || wipe_i) begin
            valid_q <= '0;
        end else if (wr_en_i) begin
            valid_q[wr_row] <= 1'b1;
        end
    end

    assign rd_line   = mem_q[rd_row];
    assign rd_data_o = valid_q[rd_row] ? rd_line[rd_col*DATA_W +: DATA_W] : '0;

    // R5
    wipe_clears_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        wipe_i |=> (valid_q == '0));

    // R9
    no_write_on_wipe_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        wr_en_i |-> !wipe_i);

endmodule

// File: rtl/sram_clr_top.sv
module sram_clr_top
    import sram_clr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 4,
    parameter int COL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_ni,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              clr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              clr_busy,
    output logic              mode_err
);

    mode_e             mode;
    logic              wipe, rd_ok, wr_ok, commit;
    logic              pend_vld;
    logic [ADDR_W-1:0] pend_addr;
    logic [DATA_W-1:0] pend_data;
    logic [DATA_W-1:0] arr_word, rd_word;

    sram_mode_decode u_dec (
        .cs_n_i  (cs_n),
        .we_n_i  (we_n),
        .oe_n_i  (oe_n),
        .clr_n_i (clr_n),
        .mode_o  (mode)
    );

    sram_clear_fsm u_fsm (
        .clk     (clk),
        .rst_ni  (rst_ni),
        .mode_i  (mode),
        .wipe_o  (wipe),
        .busy_o  (clr_busy),
        .rd_ok_o (rd_ok),
        .wr_ok_o (wr_ok)
    );

    // A held write lands when its window closes, unless a clear or an
    // illegal combination ends it
    assign commit = pend_vld && (mode != MD_WRITE) && !wipe && (mode != MD_ILLEGAL);

    sram_row_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .COL_W  (COL_W)
    ) u_arr (
        .clk       (clk),
        .rst_ni    (rst_ni),
        .wipe_i    (wipe),
        .wr_en_i   (commit),
        .wr_addr_i (pend_addr),
        .wr_data_i (pend_data),
        .rd_addr_i (addr),
        .rd_data_o (arr_word)
    );

    // Bypass for a read that coincides with the closing write
    assign rd_word = (commit && (pend_addr == addr)) ? pend_data : arr_word;

    always_ff @(posedge clk) begin
        if (!rst_ni) begin
            pend_vld  <= 1'b0;
            pend_addr <= '0;
            pend_data <= '0;
            dout      <= '0;
            dout_en   <= 1'b0;
            mode_err  <= 1'b0;
        end else begin
            pend_vld <= wr_ok;
            if (wr_ok) begin
                pend_addr <= addr;
                pend_data <= din;
            end
            dout_en  <= rd_ok;
            dout     <= rd_ok ? rd_word : '0;
            mode_err <= (mode == MD_ILLEGAL);
        end
    end

    // R4
    read_gate_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        (mode != MD_READ) |=> (!dout_en && dout == '0));

    // R7
    busy_blocks_read_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        clr_busy |=> !dout_en);

    // R9
    illegal_flag_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        (mode == MD_ILLEGAL) |=> mode_err);

endmodule

// File: tb/sim_sram_clr_top.sv
module sim_sram_clr_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_ni = 1'b0;
    logic       cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, clr_n = 1'b1;
    logic [9:0] addr = '0;
    logic [3:0] din = '0;
    logic [3:0] dout;
    logic       dout_en, clr_busy, mode_err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Reference state
    logic [3:0] ref_mem [1024];
    logic       ref_pv = 1'b0;
    logic [9:0] ref_pa = '0;
    logic [3:0] ref_pd = '0;
    logic       ref_busy = 1'b0;

    logic [6:0] exp_q [$];
    string      tag_q [$];
    logic [6:0] mon_exp, mon_act;
    string      mon_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_clr_top u0 (
        .clk      (clk),
        .rst_ni   (rst_ni),
        .cs_n     (cs_n),
        .we_n     (we_n),
        .oe_n     (oe_n),
        .clr_n    (clr_n),
        .addr     (addr),
        .din      (din),
        .dout     (dout),
        .dout_en  (dout_en),
        .clr_busy (clr_busy),
        .mode_err (mode_err)
    );

    // Driver: apply one sample and push the predicted result
    task automatic cyc(input logic cs, input logic we, input logic oe, input logic cl,
                       input logic [9:0] a, input logic [3:0] d, input string tag);
        logic sel, ill, clrm, wrm, rdm, rd, wr, commit;
        logic [3:0] ed;
        @(negedge clk);
        cs_n = cs; we_n = we; oe_n = oe; clr_n = cl; addr = a; din = d;
        sel  = !cs;
        ill  = sel && !cl && !we;
        clrm = sel && !cl && we;
        wrm  = sel && cl && !we;
        rdm  = sel && cl && we && !oe;
        rd   = rdm && !ref_busy;
        wr   = wrm && !ref_busy;
        commit = ref_pv && !wrm && !clrm && !ill;
        ed = '0;
        if (rd) ed = (commit && ref_pa == a) ? ref_pd : ref_mem[a];
        if (clrm) begin
            for (int i = 0; i < 1024; i++) ref_mem[i] = '0;
        end else if (commit) begin
            ref_mem[ref_pa] = ref_pd;
        end
        ref_pv = wr;
        if (wr) begin
            ref_pa = a;
            ref_pd = d;
        end
        ref_busy = clrm;
        exp_q.push_back({rd, ed, clrm, ill});
        tag_q.push_back(tag);
    endtask

    task automatic wr_word(input logic [9:0] a, input logic [3:0] d, input string tag);
        cyc(1'b0, 1'b0, 1'b1, 1'b1, a, d, tag);
        cyc(1'b0, 1'b1, 1'b1, 1'b1, a, 4'h0, tag);
    endtask

    task automatic rd_word(input logic [9:0] a, input string tag);
        cyc(1'b0, 1'b1, 1'b0, 1'b1, a, 4'h0, tag);
    endtask

    // Monitor: compare each cycle's outputs with the queue
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (exp_q.size() != 0) begin
            mon_exp = exp_q.pop_front();
            mon_tag = tag_q.pop_front();
            mon_act = {dout_en, dout, clr_busy, mode_err};
            checks++;
            if (mon_act !== mon_exp) begin
                failures++;
                $display("FAIL %s actual{en,dout,busy,err}=%b expected=%b",
                         mon_tag, mon_act, mon_exp);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 1024; i++) ref_mem[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset values at the ports
        checks++;
        if ({dout_en, dout, clr_busy, mode_err} !== 7'b0) begin
            failures++;
            $display("FAIL R1 actual=%b expected=%b",
                     {dout_en, dout, clr_busy, mode_err}, 7'b0);
        end
        rst_ni = 1'b1;

        cyc(1'b1, 1'b1, 1'b1, 1'b1, 10'h000, 4'h0, "R1");
        rd_word(10'h2A7, "R1");

        // R2: writes and reads at several addresses
        wr_word(10'h000, 4'h5, "R2");
        wr_word(10'h3FF, 4'hA, "R2");
        wr_word(10'h155, 4'h3, "R2");
        rd_word(10'h000, "R2");
        rd_word(10'h3FF, "R2");
        rd_word(10'h155, "R2");
        rd_word(10'h000, "R2");
        rd_word(10'h200, "R8");

        // R3: multi-cycle window, only the last sample lands
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 10'h021, 4'h1, "R3");
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 10'h022, 4'h2, "R3");
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 10'h022, 4'h6, "R3");
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 10'h000, 4'h0, "R3");
        rd_word(10'h021, "R3");
        rd_word(10'h022, "R3");

        // R10: read at the closing edge of a write
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 10'h040, 4'h9, "R10");
        rd_word(10'h040, "R10");

        // R4: non-read samples leave the output off
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 10'h000, 4'h0, "R4");
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 10'h000, 4'h0, "R4");
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 10'h0F0, 4'hC, "R4");
        rd_word(10'h0F0, "R4");

        // R6: clear with chip select high is ignored
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 10'h000, 4'h0, "R6");
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 10'h000, 4'h0, "R6");
        rd_word(10'h000, "R6");
        rd_word(10'h3FF, "R6");

        // R9: illegal combination drops the open write and does not clear
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 10'h060, 4'h7, "R9");
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 10'h060, 4'h7, "R9");
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 10'h060, 4'h0, "R9");
        rd_word(10'h060, "R9");
        rd_word(10'h000, "R9");

        // R5 and R7: clear, then a read refused in the busy cycle
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 10'h000, 4'h0, "R5");
        rd_word(10'h000, "R7");
        rd_word(10'h000, "R5");
        rd_word(10'h3FF, "R5");
        rd_word(10'h155, "R5");
        rd_word(10'h022, "R5");

        // R7: a write in the busy cycle is dropped
        wr_word(10'h100, 4'hB, "R7");
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 10'h000, 4'h0, "R7");
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 10'h100, 4'hF, "R7");
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 10'h100, 4'h0, "R7");
        rd_word(10'h100, "R7");

        // R8: zero-fill of a cleared row
        wr_word(10'h053, 4'hE, "R8");
        rd_word(10'h050, "R8");
        rd_word(10'h05F, "R8");
        rd_word(10'h053, "R8");

        // R5: held clear keeps busy high
        wr_word(10'h3C1, 4'h4, "R5");
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 10'h000, 4'h0, "R5");
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 10'h000, 4'h0, "R5");
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 10'h000, 4'h0, "R5");
        cyc(1'b1, 1'b1, 1'b1, 1'b1, 10'h000, 4'h0, "R5");
        rd_word(10'h3C1, "R5");
        cyc(1'b1, 1'b1, 1'b1, 1'b1, 10'h000, 4'h0, "R4");

        repeat (3) @(posedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule